// File: doc/BRIEF.md
# Decade Divider with Square Output

This block divides its input clock by ten. A three-stage JK counter steps through the binary codes 0 to 4 and then starts again. It stops at 4 through feedback between its own stages, not through a decoder that clears it. A fourth JK stage, wired to toggle, follows the counter and changes state once for each full pass of five. The result is a divide-by-ten output that is high for five input clocks and low for five.

The three count bits, a one-clock marker for the last count, and the square output are all visible at the ports. Taken together, the square output and the count give a plain decimal digit: the square output is worth five and the count adds 0 to 4. Reset is synchronous and clears every stage.

There is no data stream in this block, so every pin is a plain level signal with no handshake.

Top module: `decade_sqdiv`

## Requirements
- R1: While `rst` is high at a rising edge, the next output state is `cnt_o` = 0, `term_o` = 0 and `sq_o` = 0.
- R2: Out of reset, `cnt_o` increases by exactly one on each rising edge while its value is 0, 1, 2 or 3.
- R3: When `cnt_o` is 4, the next rising edge returns it to 0, so `cnt_o` never shows 5, 6 or 7 after a reset.
- R4: `term_o` is 1 exactly while `cnt_o` equals 4. It is high for one clock in every five, and its rising points are five clocks apart.
- R5: `sq_o` changes only on an edge where `term_o` was high. After reset it is low for the first five clocks and then alternates between five clocks high and five clocks low, which is a 50% duty cycle at one tenth of the clock rate.
- R6: After n rising edges out of reset, 5·`sq_o` + `cnt_o` equals n mod 10, so the outputs read as a decimal digit.
- R7: The JK control logic takes the unused codes out of the loop in one clock. 5 goes to 2, 6 goes to 2 and 7 goes to 0. Bit 0 of the count is the least significant bit and bit 2 the most significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| cnt_o | output | 3 | Modulo-5 count in binary, bit 0 least significant |
| term_o | output | 1 | High while the count is 4 |
| sq_o | output | 1 | Divide-by-ten square output |

## Verification
A wrong count stage shows up as a code outside 0 to 4, or as a skipped or repeated step, on `cnt_o` at the very next edge. A wrong feedback path turns up within five clocks as a `term_o` spacing other than five. A fault in the toggle stage shows on `sq_o` within ten clocks, as a high or low run of a length other than five or as a digit that no longer matches the edge count. Codes 5 to 7 cannot be reached through the ports, so the control logic is also swept over all eight codes on its own, and the step it produces is compared with the JK rule.

// File: rtl/decdiv_pkg.sv
package decdiv_pkg;
  // width of the modulo-5 counter
  localparam int CNT_W = 3;
  // last code of the count loop
  localparam logic [CNT_W-1:0] LAST = 3'd4;
  // stage positions inside the count word; the feedback wiring depends on them
  localparam int BIT_A = 0;
  localparam int BIT_B = 1;
  localparam int BIT_C = 2;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/jk_ff.sv
module jk_ff (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else begin
      unique case ({j, k})
        2'b00: q <= q;
        2'b01: q <= 1'b0;
        2'b10: q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end
endmodule

// File: rtl/mod5_jk_ctl.sv
module mod5_jk_ctl
  import decdiv_pkg::*;
(
  input  cnt_t q,
  output cnt_t j,
  output cnt_t k
);
  always_comb begin
    // stage A: toggles each clock, but cannot set while C is high
    j[BIT_A] = ~q[BIT_C];
    k[BIT_A] = 1'b1;
    // stage B: toggles when A is high
    j[BIT_B] = q[BIT_A];
    k[BIT_B] = q[BIT_A];
    // stage C: set on 3, cleared by its own output one clock later
    j[BIT_C] = q[BIT_A] & q[BIT_B];
    k[BIT_C] = q[BIT_C];
  end
endmodule

// File: rtl/mod5_jk_counter.sv
module mod5_jk_counter
  import decdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output cnt_t q
);
  cnt_t jv;
  cnt_t kv;

  mod5_jk_ctl u_ctl (
    .q(q),
    .j(jv),
    .k(kv)
  );

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    jk_ff u_ff (
      .clk(clk),
      .rst(rst),
      .j  (jv[i]),
      .k  (kv[i]),
      .q  (q[i])
    );
  end
endmodule

// File: rtl/decade_sqdiv.sv
module decade_sqdiv
  import decdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o,
  output logic             sq_o
);
  cnt_t cnt_q;
  logic at_last;

  mod5_jk_counter u_cnt (
    .clk(clk),
    .rst(rst),
    .q  (cnt_q)
  );

  assign at_last = (cnt_q == LAST);

  // toggle stage: flips on the edge that wraps 4 back to 0
  jk_ff u_tgl (
    .clk(clk),
    .rst(rst),
    .j  (at_last),
    .k  (at_last),
    .q  (sq_o)
  );

  assign cnt_o  = cnt_q;
  assign term_o = at_last;
endmodule

// File: rtl/decade_sqdiv_chk.sv
module decade_sqdiv_chk
  import decdiv_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] cnt,
  input logic       term,
  input logic       sq
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !sq && !term));

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt < LAST) |=> (cnt == cnt_t'($past(cnt) + 1'b1)));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (cnt == '0));

  // R3
  legal_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R4
  term_single_chk: assert property (@(posedge clk) disable iff (rst)
    term |=> !term);

  // R5
  sq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(sq));

  // R5
  sq_flip_chk: assert property (@(posedge clk) disable iff (rst)
    term |=> (sq != $past(sq)));
endmodule

bind decade_sqdiv decade_sqdiv_chk u_chk (
  .clk (clk),
  .rst (rst),
  .cnt (cnt_o),
  .term(term_o),
  .sq  (sq_o)
);

// File: tb/decade_sqdiv_tb.sv
module decade_sqdiv_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cnt_o;
  logic       term_o;
  logic       sq_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  decade_sqdiv u_dut (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt_o),
    .term_o(term_o),
    .sq_o  (sq_o)
  );

  // control logic examined on its own for the unused codes
  logic [2:0] st;
  logic [2:0] cj;
  logic [2:0] ck;
  mod5_jk_ctl u_ctl (
    .q(st),
    .j(cj),
    .k(ck)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reset, then run n clocks checking every output against edge count
  task automatic run_from_reset(input int n);
    int prev_sq;
    int run_len;
    int last_term;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 cnt", int'(cnt_o), 0);
    chk("R1 sq", int'(sq_o), 0);
    chk("R1 term", int'(term_o), 0);
    rst = 1'b0;
    prev_sq = 0;
    run_len = 1;
    last_term = -1;
    for (int e = 1; e <= n; e++) begin
      @(negedge clk);
      chk("R2 R3 cnt", int'(cnt_o), e % 5);
      chk("R4 term", int'(term_o), (e % 5 == 4) ? 1 : 0);
      chk("R5 sq", int'(sq_o), (e / 5) % 2);
      chk("R6 digit", 5 * int'(sq_o) + int'(cnt_o), e % 10);
      if (int'(sq_o) == prev_sq) run_len++;
      else begin
        chk("R5 run length", run_len, 5);
        run_len = 1;
        prev_sq = int'(sq_o);
      end
      if (term_o) begin
        if (last_term >= 0) chk("R4 spacing", e - last_term, 5);
        last_term = e;
      end
    end
  endtask

  initial begin
    int nxt;
    int exp;
    // R7: exhaustive sweep of the control logic with the JK rule
    for (int s = 0; s < 8; s++) begin
      st = 3'(s);
      #1;
      nxt = int'((cj & ~st) | (~ck & st));
      if (s < 4) exp = s + 1;
      else if (s == 4) exp = 0;
      else if (s == 7) exp = 0;
      else exp = 2;
      chk("R7 next code", nxt, exp);
    end
    // long run for period and duty
    run_from_reset(400);
    // reset applied at every phase of the ten-clock cycle
    for (int p = 0; p < 10; p++) run_from_reset(p);
    run_from_reset(37);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule